// File: doc/BRIEF.md
# Used-Ring Completion Engine

This block returns finished buffers to a shared-memory completion ring and decides whether the consumer on the far side gets an interrupt. A put request carries a head index, a total byte count and a reserved byte count. The engine writes an 8-byte completion record into the next ring slot and advances a private completion counter. It also reports how the reserved bytes split from the payload bytes. The payload copy itself is done by a separate data mover.

Completions stay invisible to the other side until a sync request arrives. A sync stores the private counter into the ring header. It then reads the flags word of the companion request ring and applies the interrupt policy: it either sets the queue cause and raises the interrupt line, or it counts a suppressed interrupt. A third request sets or clears a "do not kick me" flag in the ring header by reading, modifying and writing that word. All memory traffic goes through one 32-bit word port with byte enables and an acknowledge handshake.

Top module: `used_ring_completer`

## Requirements
- R1: A put writes two words, each with byte enables 4'b1111. The first is the head index, zero-extended, at used_base + 4 + 8*slot. The second is the total length at the next word address, used_base + 8 + 8*slot. Here slot is the private index modulo RING_SIZE. Address, enables and write flag stay stable while a memory request waits for its acknowledge.
- R2: The private index, shown on used_idx, rises by exactly one on each completed put and wraps at 16 bits. The slot therefore wraps at RING_SIZE.
- R3: A put never writes the header word at used_base. A sync writes used_idx into bits 31:16 of that word with byte enables 4'b1100.
- R4: After a sync, if bit 0 of the word at avail_base is 0, bit 0 of isr is set and irq is high in the sync_done cycle.
- R5: After a sync, if that bit is 1 and the notify-on-empty exception does not apply, skip_cnt rises by one and isr and irq keep their values.
- R6: The exception applies when feat_notify_empty and queue_empty are both 1. The interrupt is then raised even though avail bit 0 is 1.
- R7: A notify request reads the header word. It then writes it back with byte enables 4'b0011, with bit 0 set to the inverse of ntf_enable and bits 15:1 kept.
- R8: With put_done, put_skip equals the reserved count. put_fill equals total minus reserved, or 0 when the reserved count is not below the total.
- R9: Only one request runs at a time. Requests made while busy are dropped. Among requests in the same idle cycle, put wins over sync, and sync wins over notify.
- R10: isr_clr clears isr and lowers irq on the next edge. A raise on the same edge wins over the clear.
- R11: Each done output is a single-cycle pulse in the cycle after the acknowledge of the request's last memory access.
- R12: After reset, all outputs are 0 and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| used_base | input | 32 | Byte address of the completion ring header |
| avail_base | input | 32 | Byte address of the request ring flags word |
| feat_notify_empty | input | 1 | Consumer agreed to the notify-on-empty exception |
| queue_empty | input | 1 | Request ring currently has no pending entries |
| put_req | input | 1 | Start a put (one-cycle pulse) |
| put_head | input | 16 | Head index of the finished buffer chain |
| put_total | input | 32 | Total byte count reported for the buffer |
| put_resv | input | 32 | Reserved leading byte count |
| sync_req | input | 1 | Start a sync (one-cycle pulse) |
| ntf_req | input | 1 | Start a notify-flag update (one-cycle pulse) |
| ntf_enable | input | 1 | 1 clears the no-kick flag, 0 sets it |
| isr_clr | input | 1 | Clear isr and lower irq |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes at this edge |
| put_done | output | 1 | Put finished |
| put_fill | output | 32 | Payload byte count after the reserved bytes |
| put_skip | output | 32 | Reserved byte count to skip |
| sync_done | output | 1 | Sync finished |
| ntf_done | output | 1 | Notify-flag update finished |
| used_idx | output | 16 | Private completion index |
| isr | output | 8 | Interrupt cause register, bit 0 is the queue cause |
| irq | output | 1 | Interrupt line |
| skip_cnt | output | 16 | Count of suppressed interrupts |

## Verification
The timing rules below apply to every check. Memory effects land at the falling edge where the bench acknowledges. Each done pulse is high in the cycle after the rising edge that samples the last acknowledge. isr, irq, skip_cnt, used_idx and put_fill already hold their new values in that done cycle, so the bench samples all results at the falling edge where the done pulse is seen. A clear takes one edge, so its effect is checked at the next falling edge. The bench inserts random acknowledge delays, so no check depends on a fixed latency from the request. Dropped and lower-priority requests are checked by watching for several cycles that no done pulse and no header write appear.

// File: rtl/ucr_pkg.sv
package ucr_pkg;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUT_ID  = 3'd1,
    ST_PUT_LEN = 3'd2,
    ST_SYN_IDX = 3'd3,
    ST_SYN_AVF = 3'd4,
    ST_NTF_RD  = 3'd5,
    ST_NTF_WR  = 3'd6
  } ucr_state_e;

  // byte address of the record for a slot: header (4 bytes) then 8-byte records
  function automatic logic [ADDR_W-1:0] rec_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] slot);
    return base + ADDR_W'(4) + (slot << 3);
  endfunction

  // payload bytes left after the reserved prefix; never negative
  function automatic logic [31:0] fill_bytes(input logic [31:0] total,
                                             input logic [31:0] resv);
    return (resv >= total) ? 32'd0 : total - resv;
  endfunction

  // interrupt policy: raise unless suppressed, but notify-on-empty overrides
  function automatic logic want_irq(input logic no_int_flag,
                                    input logic empty_override);
    return !no_int_flag || empty_override;
  endfunction
endpackage

// File: rtl/ucr_irq.sv
module ucr_irq #(
  parameter int CNT_W     = 16,
  parameter int CAUSE_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_fire,
  input  logic             ev_skip,
  input  logic             isr_clr,
  output logic [7:0]       isr,
  output logic             irq,
  output logic [CNT_W-1:0] skip_cnt
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr      <= '0;
      irq      <= 1'b0;
      skip_cnt <= '0;
    end else begin
      if (ev_fire) begin
        isr[CAUSE_BIT] <= 1'b1;
        irq            <= 1'b1;
      end else if (isr_clr) begin
        isr <= '0;
        irq <= 1'b0;
      end
      if (ev_skip) skip_cnt <= skip_cnt + CNT_ONE;
    end
  end

  assert_fire_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> (isr[CAUSE_BIT] && irq));

  assert_skip_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> (skip_cnt == $past(skip_cnt) + CNT_ONE));

  assert_skip_keeps_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_skip && !isr_clr) |=> ($stable(isr) && $stable(irq)));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr && !ev_fire) |=> (isr == 8'h00 && !irq));
endmodule

// File: rtl/ucr_ctrl.sv
module ucr_ctrl
  import ucr_pkg::*;
#(
  parameter int RING_SIZE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] used_base,
  input  logic [ADDR_W-1:0] avail_base,
  input  logic              empty_override,
  input  logic              put_req,
  input  logic [15:0]       put_head,
  input  logic [31:0]       put_total,
  input  logic [31:0]       put_resv,
  input  logic              sync_req,
  input  logic              ntf_req,
  input  logic              ntf_enable,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              put_done,
  output logic [31:0]       put_fill,
  output logic [31:0]       put_skip,
  output logic              sync_done,
  output logic              ntf_done,
  output logic [IDX_W-1:0]  used_idx,
  output logic              ev_fire,
  output logic              ev_skip
);
  localparam int SLOT_W = $clog2(RING_SIZE);

  ucr_state_e        state;
  logic [15:0]       head_q;
  logic [31:0]       total_q;
  logic [31:0]       hdr_q;
  logic              en_q;
  logic              step;
  logic              decide;
  logic [ADDR_W-1:0] slot_ext;
  logic [ADDR_W-1:0] rec_base;

  assign step     = mem_req && mem_ack;
  assign slot_ext = ADDR_W'(used_idx[SLOT_W-1:0]);
  assign rec_base = rec_addr(used_base, slot_ext);
  assign decide   = (state == ST_SYN_AVF) && step;
  assign ev_fire  = decide &&  want_irq(mem_rdata[0], empty_override);
  assign ev_skip  = decide && !want_irq(mem_rdata[0], empty_override);

  always_comb begin
    mem_req   = (state != ST_IDLE);
    mem_we    = 1'b0;
    mem_addr  = used_base;
    mem_be    = 4'b0000;
    mem_wdata = 32'h0;
    case (state)
      ST_PUT_ID: begin
        mem_we = 1'b1; mem_addr = rec_base; mem_be = 4'b1111;
        mem_wdata = {16'h0, head_q};
      end
      ST_PUT_LEN: begin
        mem_we = 1'b1; mem_addr = rec_base + ADDR_W'(4); mem_be = 4'b1111;
        mem_wdata = total_q;
      end
      ST_SYN_IDX: begin
        mem_we = 1'b1; mem_be = 4'b1100;
        mem_wdata = {used_idx, 16'h0};
      end
      ST_SYN_AVF: mem_addr = avail_base;
      ST_NTF_WR: begin
        mem_we = 1'b1; mem_be = 4'b0011;
        mem_wdata = {hdr_q[31:1], !en_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      head_q    <= '0;
      total_q   <= '0;
      hdr_q     <= '0;
      en_q      <= 1'b0;
      put_fill  <= '0;
      put_skip  <= '0;
      used_idx  <= '0;
      put_done  <= 1'b0;
      sync_done <= 1'b0;
      ntf_done  <= 1'b0;
    end else begin
      put_done  <= 1'b0;
      sync_done <= 1'b0;
      ntf_done  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (put_req) begin
            head_q   <= put_head;
            total_q  <= put_total;
            put_fill <= fill_bytes(put_total, put_resv);
            put_skip <= put_resv;
            state    <= ST_PUT_ID;
          end else if (sync_req) begin
            state <= ST_SYN_IDX;
          end else if (ntf_req) begin
            en_q  <= ntf_enable;
            state <= ST_NTF_RD;
          end
        end
        ST_PUT_ID:  if (step) state <= ST_PUT_LEN;
        ST_PUT_LEN: if (step) begin
          used_idx <= used_idx + IDX_W'(1);
          put_done <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_SYN_IDX: if (step) state <= ST_SYN_AVF;
        ST_SYN_AVF: if (step) begin
          sync_done <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_NTF_RD: if (step) begin
          hdr_q <= mem_rdata;
          state <= ST_NTF_WR;
        end
        ST_NTF_WR: if (step) begin
          ntf_done <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    put_done |-> (used_idx == $past(used_idx) + IDX_W'(1)));

  assert_idx_only_put_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (used_idx != $past(used_idx)) |-> put_done);

  assert_one_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({put_done, sync_done, ntf_done}));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    put_done |=> !put_done);
endmodule

// File: rtl/used_ring_completer.sv
module used_ring_completer #(
  parameter int RING_SIZE = 8,
  parameter int CNT_W     = 16,
  parameter int CAUSE_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      used_base,
  input  logic [31:0]      avail_base,
  input  logic             feat_notify_empty,
  input  logic             queue_empty,
  input  logic             put_req,
  input  logic [15:0]      put_head,
  input  logic [31:0]      put_total,
  input  logic [31:0]      put_resv,
  input  logic             sync_req,
  input  logic             ntf_req,
  input  logic             ntf_enable,
  input  logic             isr_clr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             put_done,
  output logic [31:0]      put_fill,
  output logic [31:0]      put_skip,
  output logic             sync_done,
  output logic             ntf_done,
  output logic [15:0]      used_idx,
  output logic [7:0]       isr,
  output logic             irq,
  output logic [CNT_W-1:0] skip_cnt
);
  logic empty_override;
  logic ev_fire;
  logic ev_skip;

  assign empty_override = feat_notify_empty && queue_empty;

  ucr_ctrl #(.RING_SIZE(RING_SIZE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .used_base(used_base), .avail_base(avail_base),
    .empty_override(empty_override),
    .put_req(put_req), .put_head(put_head), .put_total(put_total), .put_resv(put_resv),
    .sync_req(sync_req), .ntf_req(ntf_req), .ntf_enable(ntf_enable),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .put_done(put_done), .put_fill(put_fill), .put_skip(put_skip),
    .sync_done(sync_done), .ntf_done(ntf_done), .used_idx(used_idx),
    .ev_fire(ev_fire), .ev_skip(ev_skip)
  );

  ucr_irq #(.CNT_W(CNT_W), .CAUSE_BIT(CAUSE_BIT)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_fire(ev_fire), .ev_skip(ev_skip), .isr_clr(isr_clr),
    .isr(isr), .irq(irq), .skip_cnt(skip_cnt)
  );

  assert_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_skip) |-> !(feat_notify_empty && queue_empty));

  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> !mem_req);
endmodule

// File: tb/tb_used_ring_completer.sv
`timescale 1ns/1ps
module tb_used_ring_completer;
  localparam int RING = 8;
  localparam logic [31:0] UBASE = 32'h100;
  localparam logic [31:0] ABASE = 32'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic feat_notify_empty = 1'b0, queue_empty = 1'b0;
  logic put_req = 1'b0, sync_req = 1'b0, ntf_req = 1'b0, ntf_enable = 1'b0, isr_clr = 1'b0;
  logic [15:0] put_head = '0;
  logic [31:0] put_total = '0, put_resv = '0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;
  logic put_done, sync_done, ntf_done, irq;
  logic [31:0] put_fill, put_skip;
  logic [15:0] used_idx, skip_cnt;
  logic [7:0] isr;

  logic [31:0] mem [0:255];
  int hdr_wr = 0;
  int checks = 0, fails = 0;
  logic [15:0] e_idx = '0, e_skip = '0;
  logic e_isr = 1'b0;

  always #2 clk = ~clk;

  used_ring_completer #(.RING_SIZE(RING)) dut (
    .clk(clk), .rst_n(rst_n), .used_base(UBASE), .avail_base(ABASE),
    .feat_notify_empty(feat_notify_empty), .queue_empty(queue_empty),
    .put_req(put_req), .put_head(put_head), .put_total(put_total), .put_resv(put_resv),
    .sync_req(sync_req), .ntf_req(ntf_req), .ntf_enable(ntf_enable), .isr_clr(isr_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .put_done(put_done), .put_fill(put_fill), .put_skip(put_skip),
    .sync_done(sync_done), .ntf_done(ntf_done), .used_idx(used_idx),
    .isr(isr), .irq(irq), .skip_cnt(skip_cnt)
  );

  // memory model: acknowledge after a random delay, effects land at the ack edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (rst_n && mem_req && ($urandom_range(0, 2) != 0)) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        if (mem_addr == UBASE) hdr_wr++;
      end else mem_rdata = mem[mem_addr[9:2]];
      mem_ack = 1'b1;
    end
  end

  function automatic logic [31:0] exp_fill(input logic [31:0] t, input logic [31:0] r);
    if (r < t) return t - r;
    return 32'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(input int which, input string req);
    int n = 0;
    while (!((which == 0 && put_done) || (which == 1 && sync_done) || (which == 2 && ntf_done))) begin
      @(negedge clk);
      n++;
      if (n > 200) begin
        chk(req, 32'd0, 32'd1);
        return;
      end
    end
  endtask

  task automatic do_put(input logic [15:0] h, input logic [31:0] t, input logic [31:0] r);
    logic [31:0] a;
    int hw;
    a  = UBASE + 32'd4 + 32'd8 * 32'(e_idx % RING);
    hw = hdr_wr;
    @(negedge clk);
    put_req = 1'b1; put_head = h; put_total = t; put_resv = r;
    @(negedge clk);
    put_req = 1'b0;
    wait_done(0, "R11 put_done");
    chk("R1 head word", mem[a[9:2]], {16'h0, h});
    chk("R1 length word", mem[a[9:2] + 8'd1], t);
    e_idx = e_idx + 16'd1;
    chk("R2 used_idx", 32'(used_idx), 32'(e_idx));
    chk("R8 put_fill", put_fill, exp_fill(t, r));
    chk("R8 put_skip", put_skip, r);
    chk("R3 no header write on put", 32'(hdr_wr), 32'(hw));
  endtask

  task automatic do_sync(input logic f0, input logic fe, input logic em, input logic clr_after);
    logic raise;
    mem[ABASE[9:2]] = {$urandom} & 32'hFFFF_FFFE | {31'h0, f0};
    feat_notify_empty = fe; queue_empty = em;
    raise = !f0 || (fe && em);
    @(negedge clk);
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    wait_done(1, "R11 sync_done");
    chk("R3 header index", 32'(mem[UBASE[9:2]][31:16]), 32'(e_idx));
    if (raise) e_isr = 1'b1;
    else e_skip = e_skip + 16'd1;
    chk(raise ? (f0 ? "R6 override raise isr" : "R4 raise isr") : "R5 suppressed isr",
        32'(isr), 32'(e_isr));
    chk(raise ? "R4 irq" : "R5 irq unchanged", 32'(irq), 32'(e_isr));
    chk("R5 skip_cnt", 32'(skip_cnt), 32'(e_skip));
    if (clr_after) begin
      isr_clr = 1'b1;
      @(negedge clk);
      isr_clr = 1'b0;
      e_isr = 1'b0;
      chk("R10 isr cleared", 32'(isr), 32'd0);
      chk("R10 irq lowered", 32'(irq), 32'd0);
    end
  endtask

  task automatic do_ntf(input logic en);
    logic [31:0] old;
    old = mem[UBASE[9:2]];
    old[15:0] = 16'($urandom);
    mem[UBASE[9:2]] = old;
    @(negedge clk);
    ntf_req = 1'b1; ntf_enable = en;
    @(negedge clk);
    ntf_req = 1'b0;
    wait_done(2, "R11 ntf_done");
    chk("R7 flags word", mem[UBASE[9:2]], {old[31:1], !en});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog expired: actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R12 reset isr", 32'(isr), 32'd0);
    chk("R12 reset irq/req", {30'h0, irq, mem_req}, 32'd0);
    chk("R12 reset used_idx", 32'(used_idx), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    do_put(16'h0005, 32'd1500, 32'd12);
    do_put(16'h0003, 32'd100, 32'd100);        // R8 reserved equals total
    do_put(16'h0007, 32'd10, 32'd40);           // R8 reserved above total
    do_sync(1'b0, 1'b0, 1'b0, 1'b0);            // R4
    do_sync(1'b1, 1'b0, 1'b1, 1'b1);            // R5, then R10
    do_sync(1'b1, 1'b1, 1'b1, 1'b1);            // R6
    do_sync(1'b1, 1'b1, 1'b0, 1'b0);            // R5 feature but not empty
    do_ntf(1'b0);
    do_ntf(1'b1);

    // R11 single-cycle done pulse
    do_put(16'h0001, 32'd64, 32'd0);
    @(negedge clk);
    chk("R11 put_done one cycle", 32'(put_done), 32'd0);

    // R10 raise on the same edge as a held clear wins
    isr_clr = 1'b1;
    do_sync(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    isr_clr = 1'b0;
    e_isr = 1'b0;
    chk("R10 cleared after raise", 32'(irq), 32'd0);

    // R9 request while busy is dropped
    begin
      int hw;
      bit seen;
      hw = hdr_wr;
      seen = 1'b0;
      @(negedge clk);
      put_req = 1'b1; put_head = 16'h00AA; put_total = 32'd8; put_resv = 32'd0;
      @(negedge clk);
      put_req = 1'b0; sync_req = 1'b1;
      @(negedge clk);
      sync_req = 1'b0;
      wait_done(0, "R9 put_done");
      e_idx = e_idx + 16'd1;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (sync_done) seen = 1'b1;
      end
      chk("R9 busy sync dropped", {31'h0, seen}, 32'd0);
      chk("R9 no header write", 32'(hdr_wr), 32'(hw));
    end

    // R9 priority: put wins over simultaneous sync and notify
    begin
      int hw;
      bit seen;
      hw = hdr_wr;
      seen = 1'b0;
      @(negedge clk);
      put_req = 1'b1; sync_req = 1'b1; ntf_req = 1'b1;
      put_head = 16'h0BB; put_total = 32'd20; put_resv = 32'd4;
      @(negedge clk);
      put_req = 1'b0; sync_req = 1'b0; ntf_req = 1'b0;
      wait_done(0, "R9 priority put_done");
      e_idx = e_idx + 16'd1;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (sync_done || ntf_done) seen = 1'b1;
      end
      chk("R9 lower priority dropped", {31'h0, seen}, 32'd0);
      chk("R9 priority header untouched", 32'(hdr_wr), 32'(hw));
    end

    // random mix, including ring wrap
    for (int k = 0; k < 40; k++) begin
      case ($urandom_range(0, 3))
        0, 1: do_put(16'($urandom), 32'($urandom_range(1, 9000)), 32'($urandom_range(0, 9100)));
        2:    do_sync(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        default: do_ntf(1'($urandom));
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule